// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen word transfers without help from the processor. Software fills three local memories through a byte-wide write port. The command memory holds one control byte per queue slot. The transmit memory holds two bytes per slot, and the receive memory holds two bytes per slot. Software also sets the clock mode, the clock divider and a pair of 4-bit queue pointers, and then writes a go bit.

The controller then runs each slot from the first pointer to the last pointer inclusive, stepping modulo 16. Each slot drives its own select pattern and moves one 16-bit word in both directions at once, most significant bit first. When the last slot finishes, the controller releases the selects, parks the serial clock at its idle level and raises a sticky done flag. Software polls the done flag, reads the received bytes back through the read port, and clears the flag by writing a one.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, `ss_n` is all ones, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: Writing 1 to bit 0 at address 0x63 while idle starts the queue. Slots run from the first pointer (0x62 bits 3:0) to the last pointer (0x62 bits 7:4) inclusive. Each slot shifts 16 bits out on `mosi`, MSB first, in exactly 32 `sclk` edges. The word's high byte is the transmit byte at 0x20+2i and its low byte is the one at 0x21+2i.
- R3: The 16 bits sampled from `miso` during slot i are stored with the high byte readable at 0x40+2i and the low byte at 0x41+2i.
- R4: When the last pointer is below the first pointer, the slot index wraps from 15 to 0, giving ((last-first) mod 16)+1 slots.
- R5: Mode byte at 0x60 has bit 0 as polarity and bit 1 as phase. While idle, `sclk` equals the polarity bit. With phase 0, the first bit is on `mosi` before the first edge, data is sampled on each leading edge and changed on each trailing edge. With phase 1, data is changed on leading edges and sampled on trailing edges.
- R6: Each `sclk` half period lasts D system clocks, where D is the divider byte at 0x61 and a value of 0 acts as 1.
- R7: In a command byte, bits 3:0 give the selects to drive low on `ss_n[3:0]` during that slot. Bit 4 set keeps the select asserted straight into the next slot. With bit 4 clear, `ss_n` returns to all ones between slots. After the last slot, `ss_n` always returns to all ones.
- R8: `done` rises when the last slot completes, in the same cycle that `busy` falls. It is cleared by writing 1 to bit 1 at 0x63, or by a new start.
- R9: While `busy`, a start write has no effect. Writes to the command and transmit memories, the mode byte, the divider and the pointers are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register/memory port |
| wr_addr | input | 7 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 7 | Read address (combinational read) |
| rd_data | output | 8 | Read data: memories, settings, status {busy,done} at 0x63 |
| busy | output | 1 | Queue is running |
| done | output | 1 | Sticky completion flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss_n | output | 4 | Active-low slave selects |

## Verification
The bench goes after a queue whose last pointer is below its first pointer. A design that compares pointers by magnitude there would run the wrong number of slots or stop early. All four clock modes are run against a bench slave that follows the mode rules on its own. A phase mix-up would show as words shifted by one bit in both directions. A zero divider, a single-slot queue, and mixed select-hold bits are tested, so a design that stretched or dropped a half period, or released or held selects wrongly, would produce the wrong edge timing or the wrong count of select releases. A run is also disturbed by a second start and by writes to memories and settings. A design that honoured those writes would show extra edges, a changed transmit word or a changed clock rate.

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [6:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [6:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [SEL_W-1:0] ss_n
);
  localparam int SLOTS = 16;
  localparam int BYTES = 2 * SLOTS;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LEAD, S_SHIFT, S_TAIL, S_DESEL} st_t;

  st_t              state;
  logic [7:0]       cmd_mem [SLOTS];
  logic [7:0]       tx_mem  [BYTES];
  logic [7:0]       rx_mem  [BYTES];
  logic             cpol, cpha, ph;
  logic [DIV_W-1:0] div, cnt;
  logic [3:0]       qs, qe, cur;
  logic [4:0]       ecnt;
  logic [15:0]      tx_sr, rx_sr;
  logic [SEL_W-1:0] ss_q;

  wire idle   = (state == S_IDLE);
  wire wr_cmd = wr_en && (wr_addr[6:4] == 3'b000);
  wire wr_tx  = wr_en && (wr_addr[6:5] == 2'b01);
  wire wr_cfg = wr_en && (wr_addr == 7'h60);
  wire wr_div = wr_en && (wr_addr == 7'h61);
  wire wr_ptr = wr_en && (wr_addr == 7'h62);
  wire wr_ctl = wr_en && (wr_addr == 7'h63);
  wire go     = wr_ctl && wr_data[0] && idle;

  wire [DIV_W-1:0] half = (div == '0) ? DIV_W'(1) : div;
  wire tick = (cnt == half - DIV_W'(1));
  wire smp  = cpha ? ecnt[0] : ~ecnt[0];
  wire shf  = cpha ? (~ecnt[0] && (ecnt != 5'd0)) : ecnt[0];

  assign busy = !idle;
  assign sclk = ph ^ cpol;
  assign mosi = tx_sr[15];
  assign ss_n = ss_q;

  always_ff @(posedge clk) begin
    if (wr_cmd && idle) cmd_mem[wr_addr[3:0]] <= wr_data;
    if (wr_tx && idle)  tx_mem[wr_addr[4:0]]  <= wr_data;
    if (state == S_TAIL && tick) begin
      rx_mem[{cur, 1'b0}] <= rx_sr[15:8];
      rx_mem[{cur, 1'b1}] <= rx_sr[7:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[6:4] == 3'b000)      rd_data = cmd_mem[rd_addr[3:0]];
    else if (rd_addr[6:5] == 2'b01)  rd_data = tx_mem[rd_addr[4:0]];
    else if (rd_addr[6:5] == 2'b10)  rd_data = rx_mem[rd_addr[4:0]];
    else begin
      case (rd_addr)
        7'h60:   rd_data = {6'd0, cpha, cpol};
        7'h61:   rd_data = 8'(div);
        7'h62:   rd_data = {qe, qs};
        7'h63:   rd_data = {6'd0, busy, done};
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cpol  <= 1'b0;
      cpha  <= 1'b0;
      div   <= DIV_W'(1);
      qs    <= '0;
      qe    <= '0;
      cur   <= '0;
      done  <= 1'b0;
      ph    <= 1'b0;
      cnt   <= '0;
      ecnt  <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      ss_q  <= '1;
    end else begin
      if (wr_cfg && idle) {cpha, cpol} <= wr_data[1:0];
      if (wr_div && idle) div <= wr_data[DIV_W-1:0];
      if (wr_ptr && idle) begin
        qs <= wr_data[3:0];
        qe <= wr_data[7:4];
      end
      if (wr_ctl && wr_data[1]) done <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          cur   <= qs;
          done  <= 1'b0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          ss_q  <= ~cmd_mem[cur][SEL_W-1:0];
          tx_sr <= {tx_mem[{cur, 1'b0}], tx_mem[{cur, 1'b1}]};
          cnt   <= '0;
          state <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          cnt   <= '0;
          ecnt  <= '0;
          state <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (tick) begin
          cnt  <= '0;
          ph   <= ~ph;
          ecnt <= ecnt + 1'b1;
          if (smp) rx_sr <= {rx_sr[14:0], miso};
          if (shf) tx_sr <= {tx_sr[14:0], 1'b0};
          if (ecnt == 5'd31) state <= S_TAIL;
        end else cnt <= cnt + 1'b1;
        S_TAIL: if (tick) begin
          cnt <= '0;
          if (cur == qe) begin
            ss_q  <= '1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cur <= cur + 1'b1;
            if (cmd_mem[cur][SEL_W]) state <= S_LOAD;
            else begin
              ss_q  <= '1;
              state <= S_DESEL;
            end
          end
        end else cnt <= cnt + 1'b1;
        S_DESEL: if (tick) begin
          cnt   <= '0;
          state <= S_LOAD;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sclk == cpol));
  assert_idle_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ss_n == '1));
  assert_settings_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(div) && $stable(qs) && $stable(qe) && $stable(cpol) && $stable(cpha)));
  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == S_TAIL));
  assert_half_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |-> (cnt < half));
  assert_even_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TAIL) |-> (ph == 1'b0));
endmodule

// File: tb/tb_spi_queue_master.sv
`timescale 1ns/1ps
module tb_spi_queue_master;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       busy, done, sclk, mosi, miso;
  logic [3:0] ss_n;

  int total = 0, bad = 0;
  int ec = 0, rel = 0;
  bit arm = 1'b0, s_cpha = 1'b0;
  logic [15:0] reply [16];
  logic [15:0] got [16];
  logic [3:0]  sel_seen [16];
  realtime t_e0 = 0.0, t_e1 = 0.0;

  always #2.5 clk = ~clk;

  spi_queue_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always_comb begin
    int e;
    e = s_cpha ? ((ec > 0) ? ec - 1 : 0) : ec;
    miso = reply[(e / 32) % 16][15 - ((e % 32) / 2)];
  end

  always @(sclk) begin
    if (arm && ss_n != 4'hF) begin
      int e, k, i;
      e = ec; k = (e / 32) % 16; i = (e % 32) / 2;
      if ((e % 2) == int'(s_cpha)) begin
        got[k][15 - i] = mosi;
        if (i == 0) sel_seen[k] = ss_n;
      end
      if (e == 0) t_e0 = $realtime;
      if (e == 1) t_e1 = $realtime;
      ec = ec + 1;
    end
  end

  always @(ss_n) if (arm && ss_n == 4'hF) rel = rel + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic run(input bit pol, input bit pha, input logic [7:0] dv,
                     input logic [3:0] qs, input logic [3:0] qe, input bit disturb);
    logic [7:0]  cmd [16];
    logic [15:0] txw [16];
    logic [7:0]  hi, lo;
    int n, exp_rel, edv, t;
    wr(7'h60, {6'd0, pha, pol});
    wr(7'h61, dv);
    wr(7'h62, {qe, qs});
    for (int i = 0; i < 16; i++) begin
      cmd[i] = {3'b000, 1'($urandom_range(0, 1)), 4'($urandom_range(1, 15))};
      txw[i] = 16'($urandom);
      reply[i] = 16'($urandom);
      wr(7'(i), cmd[i]);
      wr(7'(32 + 2 * i), txw[i][15:8]);
      wr(7'(33 + 2 * i), txw[i][7:0]);
    end
    n = int'(4'(qe - qs)) + 1;
    @(negedge clk);
    chk(sclk == pol, "R5", "idle sclk level", sclk, pol);
    ec = 0; rel = 0; s_cpha = pha; arm = 1'b1;
    wr(7'h63, 8'h01);
    if (disturb) begin
      wr(7'h63, 8'h01);
      wr(7'(32 + 2 * qe), ~txw[qe][15:8]);
      wr(7'(qe), 8'h0F);
      wr(7'h61, dv + 8'd3);
      wr(7'h62, 8'h00);
      wr(7'h60, {6'd0, ~pha, ~pol});
      wr(7'h63, 8'h01);
    end
    t = 0;
    while (!done && t < 30000) begin @(negedge clk); t++; end
    arm = 1'b0;
    chk(done == 1'b1, "R8", "done after queue", done, 1);
    chk(busy == 1'b0, "R8", "busy after queue", busy, 0);
    chk(ss_n == 4'hF, "R7", "selects released", ss_n, 4'hF);
    chk(sclk == pol, "R5", "sclk parked", sclk, pol);
    chk(ec == 32 * n, "R2", "edge count (R4 slot count, R9 restart)", ec, 32 * n);
    exp_rel = 1;
    for (int k = 0; k < n; k++) begin
      int e;
      e = (int'(qs) + k) % 16;
      if (k < n - 1 && !cmd[e][4]) exp_rel++;
      chk(got[k] == txw[e], "R2", "mosi word", got[k], txw[e]);
      chk(sel_seen[k] == ~cmd[e][3:0], "R7", "select pattern", sel_seen[k], ~cmd[e][3:0]);
      rd(7'(64 + 2 * e), hi);
      rd(7'(65 + 2 * e), lo);
      chk({hi, lo} == reply[k], "R3", "received word", {hi, lo}, reply[k]);
    end
    chk(rel == exp_rel, "R7", "select releases", rel, exp_rel);
    edv = (dv == 8'd0) ? 1 : int'(dv);
    chk(int'((t_e1 - t_e0) / 5.0) == edv, "R6", "half period clocks", int'((t_e1 - t_e0) / 5.0), edv);
    if (disturb) begin
      rd(7'(32 + 2 * qe), hi);
      chk(hi == txw[qe][15:8], "R9", "tx byte write ignored", hi, txw[qe][15:8]);
      rd(7'h62, hi);
      chk(hi == {qe, qs}, "R9", "pointer write ignored", hi, {qe, qs});
    end
    wr(7'h63, 8'h02);
    chk(done == 1'b0, "R8", "done cleared", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ss_n == 4'hF, "R1", "reset ss_n", ss_n, 4'hF);
    chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    run(1'b0, 1'b0, 8'd1, 4'd0, 4'd15, 1'b0);
    run(1'b1, 1'b1, 8'd0, 4'd3, 4'd6, 1'b0);
    run(1'b0, 1'b1, 8'd2, 4'd12, 4'd3, 1'b0);
    run(1'b1, 1'b0, 8'd3, 4'd5, 4'd5, 1'b0);
    run(1'b0, 1'b0, 8'd2, 4'd14, 4'd1, 1'b1);
    for (int r = 0; r < 6; r++)
      run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 4)),
          4'($urandom), 4'($urandom), 1'($urandom_range(0, 1)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule